// File: doc/BRIEF.md
# Trace Event Resource Combiner

This block turns a set of trace-related status bits into a single event bit. A 17-bit event word, held in one programmable register, names two resources, A and B. Each resource is named by a 7-bit identifier made of a 3-bit resource class and a 4-bit slot. The word also holds a 3-bit code that picks one of eight two-input Boolean functions. The selected resources are combined by that function, and the result is driven out without a register, so the event follows the status inputs in the same cycle.

The status inputs are the results of comparators and flags that are built elsewhere:

- single address comparators
- range comparators
- software flags
- watchpoints
- counter-at-zero flags
- sequencer states
- context and virtual-machine comparators
- the trace start/stop resource
- external inputs and extended input selectors
- the non-secure indication and the trace-prohibit indication

One resource slot is always true. Selecting it with the plain or the inverted pass-through function forces the event permanently on or off. The event word is loaded through a simple write-only bus, at a byte offset of four times a parameterised register number.

Top module: `evt_combiner`

## Requirements
- R1: After reset the event word is all zeros. The function is therefore pass A, with A set to class 0 slot 0, so `evt_out` equals `addr_cmp[0]`.
- R2: A write with `wr_en` high and `wr_addr` equal to 4×REG_NUM loads `wr_data` into the event word at the next rising clock edge. A write to any other address leaves the event word, and so `evt_out`, unchanged.
- R3: The event word layout is function code in bits [16:14], resource B identifier in [13:7] and resource A identifier in [6:0]. Within an identifier, bits [6:4] are the class and bits [3:0] are the slot.
- R4: The function codes are:
  - 0 = A
  - 1 = not A
  - 2 = A and B
  - 3 = not A and B
  - 4 = not A and not B
  - 5 = A or B
  - 6 = not A or B
  - 7 = not A or not B
- R5: Class 0 slots 0–15 select `addr_cmp[0..15]`. In class 1, slots 0–7 select `range_cmp[0..7]` and slots 8–11 select `sw_flag[0..3]`.
- R6: Class 2 slots 0–7 select `wpt_cmp[0..7]`. Class 4 slots 0–3 select `cnt_zero[0..3]`.
- R7: Class 5 maps its slots as follows:
  - slots 0–2 select `seq_state[0..2]`
  - slots 8–10 select `ctx_cmp[0..2]`
  - slot 11 selects `vmid_cmp`
  - slot 15 selects `trc_ss`
- R8: Class 6 maps its slots as follows:
  - slots 0–3 select `ext_in[0..3]`
  - slots 8–11 select `ext_sel[0..3]`
  - slot 13 selects `nonsecure`
  - slot 14 selects `trc_prohibit`
  - slot 15 is constant 1
- R9: Every other identifier reads as 0. These are:
  - classes 3 and 7
  - class 1 slots 12–15
  - class 2 slots 8–15
  - class 4 slots 4–15
  - class 5 slots 3–7 and 12–14
  - class 6 slots 4–7 and 12
- R10: Identifier 0x6F (class 6, slot 15) with function 0 holds `evt_out` at 1, and with function 1 holds it at 0, whatever the status inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 17 | Event word to store |
| addr_cmp | input | 16 | Single address comparator results |
| range_cmp | input | 8 | Address range comparator results |
| sw_flag | input | 4 | Software-controlled flags |
| wpt_cmp | input | 8 | Watchpoint comparator results |
| cnt_zero | input | 4 | Counter-at-zero flags |
| seq_state | input | 3 | Sequencer in state 1–3 |
| ctx_cmp | input | 3 | Context ID comparator results |
| vmid_cmp | input | 1 | Virtual machine ID comparator result |
| trc_ss | input | 1 | Trace start/stop resource |
| ext_in | input | 4 | External inputs |
| ext_sel | input | 4 | Extended external input selectors |
| nonsecure | input | 1 | Processor in non-secure state |
| trc_prohibit | input | 1 | Trace prohibited |
| evt_out | output | 1 | Combined event |

## Verification
A write is driven on a falling edge and takes effect at the following rising edge. The bench therefore compares `evt_out` for a new event word at the next falling edge, one clock after the write is presented. A change on a status input reaches `evt_out` in the same cycle, so those checks sample 2 ns after the inputs are driven, well before the next rising edge. Random event words and random status vectors are compared against a bench model of the class/slot table and the function codes. Directed cases cover the reset word, every reserved hole, the forcing identifier and a write to the wrong address.

// File: rtl/evt_pkg.sv
// Package evt_pkg
// Shared widths, field layout and function codes for the event combiner.
// Assumes the class/slot encoding is fixed; counts follow that encoding.
package evt_pkg;
    localparam int ID_W     = 7;
    localparam int CLASS_W  = 3;
    localparam int SLOT_W   = ID_W - CLASS_W;
    localparam int FN_W     = 3;
    localparam int WORD_W   = FN_W + 2 * ID_W;
    localparam int TBL_N    = 1 << ID_W;
    localparam int SLOTS    = 1 << SLOT_W;
    localparam int N_SRC    = 2;

    localparam int N_ADDR   = 16;
    localparam int N_RANGE  = 8;
    localparam int N_SWF    = 4;
    localparam int N_WPT    = 8;
    localparam int N_CNT    = 4;
    localparam int N_SEQ    = 3;
    localparam int N_CTX    = 3;
    localparam int N_EXT    = 4;
    localparam int N_XSEL   = 4;

    typedef enum logic [FN_W-1:0] {
        FN_A        = 3'd0,
        FN_NA       = 3'd1,
        FN_A_B      = 3'd2,
        FN_NA_B     = 3'd3,
        FN_NA_NB    = 3'd4,
        FN_AOR_B    = 3'd5,
        FN_NAOR_B   = 3'd6,
        FN_NAOR_NB  = 3'd7
    } fn_e;

    typedef struct packed {
        logic [FN_W-1:0] fn;
        logic [ID_W-1:0] id_b;
        logic [ID_W-1:0] id_a;
    } evt_word_t;
endpackage

// File: rtl/evt_cfg_reg.sv
// Module evt_cfg_reg
// Holds the event word. Loads it on a write strobe whose byte address
// equals four times REG_NUM. Synchronous active-low reset clears it.
// Assumes writes are single-cycle strobes; no read path exists.
module evt_cfg_reg
    import evt_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int REG_NUM = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output evt_word_t         word
);
    localparam logic [ADDR_W-1:0] BYTE_OFS = ADDR_W'(REG_NUM * 4);

    logic hit;

    // Decode a write aimed at this register.
    always_comb begin
        hit = wr_en && (wr_addr == BYTE_OFS);
    end

    // Store the event word on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (hit) begin
            word <= evt_word_t'(wr_data);
        end
    end

    assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == BYTE_OFS) |=> (word == $past(wr_data)));

    assert_other_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == BYTE_OFS) |=> $stable(word));
endmodule

// File: rtl/evt_res_map.sv
// Module evt_res_map
// Lays the status inputs out as a table indexed by the 7-bit identifier.
// Each class owns 16 slots; holes and unused classes are tied to 0,
// and class 6 slot 15 is tied to 1.
module evt_res_map
    import evt_pkg::*;
(
    input  logic [N_ADDR-1:0]  addr_cmp,
    input  logic [N_RANGE-1:0] range_cmp,
    input  logic [N_SWF-1:0]   sw_flag,
    input  logic [N_WPT-1:0]   wpt_cmp,
    input  logic [N_CNT-1:0]   cnt_zero,
    input  logic [N_SEQ-1:0]   seq_state,
    input  logic [N_CTX-1:0]   ctx_cmp,
    input  logic               vmid_cmp,
    input  logic               trc_ss,
    input  logic [N_EXT-1:0]   ext_in,
    input  logic [N_XSEL-1:0]  ext_sel,
    input  logic               nonsecure,
    input  logic               trc_prohibit,
    output logic [TBL_N-1:0]   tbl
);
    logic [SLOTS-1:0] cls [8];

    // Fill each class row; unlisted slots stay 0.
    always_comb begin
        for (int c = 0; c < 8; c++) cls[c] = '0;
        cls[0]                 = addr_cmp;
        cls[1][N_RANGE-1:0]    = range_cmp;
        cls[1][8 +: N_SWF]     = sw_flag;
        cls[2][N_WPT-1:0]      = wpt_cmp;
        cls[4][N_CNT-1:0]      = cnt_zero;
        cls[5][N_SEQ-1:0]      = seq_state;
        cls[5][8 +: N_CTX]     = ctx_cmp;
        cls[5][11]             = vmid_cmp;
        cls[5][15]             = trc_ss;
        cls[6][N_EXT-1:0]      = ext_in;
        cls[6][8 +: N_XSEL]    = ext_sel;
        cls[6][13]             = nonsecure;
        cls[6][14]             = trc_prohibit;
        cls[6][15]             = 1'b1;
    end

    genvar g;
    generate
        for (g = 0; g < 8; g++) begin : g_row
            assign tbl[g*SLOTS +: SLOTS] = cls[g];
        end
    endgenerate
endmodule

// File: rtl/evt_res_sel.sv
// Module evt_res_sel
// Picks one resource bit from the identifier-indexed table.
// Assumes the table already holds 0 for every reserved identifier.
module evt_res_sel
    import evt_pkg::*;
(
    input  logic [TBL_N-1:0] tbl,
    input  logic [ID_W-1:0]  id,
    output logic             val
);
    // Index the table by the identifier.
    always_comb begin
        val = tbl[id];
    end
endmodule

// File: rtl/evt_bool_fn.sv
// Module evt_bool_fn
// Applies the two-input Boolean function chosen by the 3-bit code.
// Purely combinational.
module evt_bool_fn
    import evt_pkg::*;
(
    input  logic [FN_W-1:0] fn,
    input  logic            a,
    input  logic            b,
    output logic            y
);
    // Evaluate the selected function.
    always_comb begin
        case (fn_e'(fn))
            FN_A:       y = a;
            FN_NA:      y = !a;
            FN_A_B:     y = a && b;
            FN_NA_B:    y = !a && b;
            FN_NA_NB:   y = !a && !b;
            FN_AOR_B:   y = a || b;
            FN_NAOR_B:  y = !a || b;
            default:    y = !a || !b;
        endcase
    end
endmodule

// File: rtl/evt_combiner.sv
// Module evt_combiner
// Top of the event combiner. It stores one event word, selects two
// resources by identifier and drives their Boolean combination.
// The output is combinational from the stored word and status inputs.
module evt_combiner
    import evt_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int REG_NUM = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [16:0]       wr_data,
    input  logic [15:0]       addr_cmp,
    input  logic [7:0]        range_cmp,
    input  logic [3:0]        sw_flag,
    input  logic [7:0]        wpt_cmp,
    input  logic [3:0]        cnt_zero,
    input  logic [2:0]        seq_state,
    input  logic [2:0]        ctx_cmp,
    input  logic              vmid_cmp,
    input  logic              trc_ss,
    input  logic [3:0]        ext_in,
    input  logic [3:0]        ext_sel,
    input  logic              nonsecure,
    input  logic              trc_prohibit,
    output logic              evt_out
);
    evt_word_t        word;
    logic [TBL_N-1:0] tbl;
    logic [ID_W-1:0]  sel_id  [N_SRC];
    logic             sel_val [N_SRC];

    evt_cfg_reg #(.ADDR_W(ADDR_W), .REG_NUM(REG_NUM)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .word    (word)
    );

    evt_res_map map_i (
        .addr_cmp     (addr_cmp),
        .range_cmp    (range_cmp),
        .sw_flag      (sw_flag),
        .wpt_cmp      (wpt_cmp),
        .cnt_zero     (cnt_zero),
        .seq_state    (seq_state),
        .ctx_cmp      (ctx_cmp),
        .vmid_cmp     (vmid_cmp),
        .trc_ss       (trc_ss),
        .ext_in       (ext_in),
        .ext_sel      (ext_sel),
        .nonsecure    (nonsecure),
        .trc_prohibit (trc_prohibit),
        .tbl          (tbl)
    );

    // Route the A and B identifiers out of the stored word.
    always_comb begin
        sel_id[0] = word.id_a;
        sel_id[1] = word.id_b;
    end

    genvar s;
    generate
        for (s = 0; s < N_SRC; s++) begin : g_sel
            evt_res_sel sel_i (
                .tbl (tbl),
                .id  (sel_id[s]),
                .val (sel_val[s])
            );
        end
    endgenerate

    evt_bool_fn fn_i (
        .fn (word.fn),
        .a  (sel_val[0]),
        .b  (sel_val[1]),
        .y  (evt_out)
    );

    assert_force_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (word.id_a == 7'h6F && word.fn == FN_A) |-> evt_out);

    assert_force_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (word.id_a == 7'h6F && word.fn == FN_NA) |-> !evt_out);

    assert_reserved_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (word.id_a[6:4] == 3'd3 || word.id_a[6:4] == 3'd7) |-> !sel_val[0]);

    assert_and_needs_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word.fn == FN_A_B && evt_out) |-> (sel_val[0] && sel_val[1]));

    assert_addr_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word.id_a[6:4] == 3'd0) |-> (sel_val[0] == addr_cmp[word.id_a[3:0]]));
endmodule

// File: tb/evt_combiner_tb.sv
// Bench for evt_combiner: directed corner cases plus seeded random words
// and status vectors, compared against a model built from the requirements.
module evt_combiner_tb_top;
    localparam int ADDR_W  = 12;
    localparam int REG_NUM = 8;
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_NUM * 4);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [16:0] wr_data = '0;
    logic [15:0] addr_cmp = '0;
    logic [7:0]  range_cmp = '0;
    logic [3:0]  sw_flag = '0;
    logic [7:0]  wpt_cmp = '0;
    logic [3:0]  cnt_zero = '0;
    logic [2:0]  seq_state = '0;
    logic [2:0]  ctx_cmp = '0;
    logic        vmid_cmp = 1'b0;
    logic        trc_ss = 1'b0;
    logic [3:0]  ext_in = '0;
    logic [3:0]  ext_sel = '0;
    logic        nonsecure = 1'b0;
    logic        trc_prohibit = 1'b0;
    logic        evt_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic [16:0] cur_word = '0;

    always #10 clk = ~clk;

    evt_combiner #(.ADDR_W(ADDR_W), .REG_NUM(REG_NUM)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .addr_cmp(addr_cmp), .range_cmp(range_cmp),
        .sw_flag(sw_flag), .wpt_cmp(wpt_cmp), .cnt_zero(cnt_zero),
        .seq_state(seq_state), .ctx_cmp(ctx_cmp), .vmid_cmp(vmid_cmp),
        .trc_ss(trc_ss), .ext_in(ext_in), .ext_sel(ext_sel),
        .nonsecure(nonsecure), .trc_prohibit(trc_prohibit), .evt_out(evt_out)
    );

    function automatic logic ref_res(input logic [6:0] id);
        logic [3:0] k;
        k = id[3:0];
        case (id[6:4])
            3'd0: return addr_cmp[k];
            3'd1: return (k < 8) ? range_cmp[k[2:0]] : (k < 12) ? sw_flag[k[1:0]] : 1'b0;
            3'd2: return (k < 8) ? wpt_cmp[k[2:0]] : 1'b0;
            3'd4: return (k < 4) ? cnt_zero[k[1:0]] : 1'b0;
            3'd5: begin
                if (k < 3) return seq_state[k[1:0]];
                if (k >= 8 && k < 11) return ctx_cmp[k - 4'd8];
                if (k == 11) return vmid_cmp;
                if (k == 15) return trc_ss;
                return 1'b0;
            end
            3'd6: begin
                if (k < 4) return ext_in[k[1:0]];
                if (k >= 8 && k < 12) return ext_sel[k[1:0]];
                if (k == 13) return nonsecure;
                if (k == 14) return trc_prohibit;
                if (k == 15) return 1'b1;
                return 1'b0;
            end
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic ref_evt(input logic [16:0] w);
        logic a, b;
        a = ref_res(w[6:0]);
        b = ref_res(w[13:7]);
        case (w[16:14])
            3'd0: return a;
            3'd1: return ~a;
            3'd2: return a & b;
            3'd3: return ~a & b;
            3'd4: return ~a & ~b;
            3'd5: return a | b;
            3'd6: return ~a | b;
            default: return ~a | ~b;
        endcase
    endfunction

    task automatic check(input string req, input logic exp);
        n_cmp++;
        if (evt_out !== exp) begin
            n_bad++;
            $display("FAIL %s word=%h got=%b exp=%b", req, cur_word, evt_out, exp);
        end
    endtask

    task automatic put_word(input logic [ADDR_W-1:0] a, input logic [16:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == OFS) cur_word = d;
    endtask

    task automatic rand_status();
        addr_cmp = 16'($urandom); range_cmp = 8'($urandom); sw_flag = 4'($urandom);
        wpt_cmp = 8'($urandom); cnt_zero = 4'($urandom); seq_state = 3'($urandom);
        ctx_cmp = 3'($urandom); vmid_cmp = 1'($urandom); trc_ss = 1'($urandom);
        ext_in = 4'($urandom); ext_sel = 4'($urandom); nonsecure = 1'($urandom);
        trc_prohibit = 1'($urandom);
    endtask

    task automatic all_status(input logic v);
        addr_cmp = {16{v}}; range_cmp = {8{v}}; sw_flag = {4{v}}; wpt_cmp = {8{v}};
        cnt_zero = {4{v}}; seq_state = {3{v}}; ctx_cmp = {3{v}}; vmid_cmp = v;
        trc_ss = v; ext_in = {4{v}}; ext_sel = {4{v}}; nonsecure = v; trc_prohibit = v;
    endtask

    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5171));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset word passes address comparator 0
        addr_cmp = 16'h0001; #2; check("R1", 1'b1);
        addr_cmp = 16'hFFFE; #2; check("R1", 1'b0);

        // R9: every identifier with status all ones; pass A (also R5..R8 map)
        all_status(1'b1);
        for (int id = 0; id < 128; id++) begin
            put_word(OFS, {3'd0, 7'd0, 7'(id)});
            check("R9", ref_evt(cur_word));
        end

        // R3: B field position, function 2 with A forced true
        all_status(1'b0);
        addr_cmp[5] = 1'b1;
        put_word(OFS, {3'd2, 7'h05, 7'h6F});
        check("R3", 1'b1);
        addr_cmp[5] = 1'b0; #2; check("R3", 1'b0);

        // R10: forcing on/off with any status
        put_word(OFS, {3'd0, 7'h00, 7'h6F});
        all_status(1'b0); #2; check("R10", 1'b1);
        put_word(OFS, {3'd1, 7'h00, 7'h6F});
        all_status(1'b1); #2; check("R10", 1'b0);

        // R2: write at another address is ignored
        put_word(OFS, {3'd0, 7'h00, 7'h6F});
        put_word(OFS + 12'd4, {3'd1, 7'h00, 7'h6F});
        check("R2", 1'b1);
        put_word(OFS ^ 12'h800, {3'd1, 7'h00, 7'h6F});
        check("R2", 1'b1);

        // R4: all function codes over all A/B values (ext_in[0]=A, ext_in[1]=B)
        for (int f = 0; f < 8; f++) begin
            put_word(OFS, {3'(f), 7'h61, 7'h60});
            for (int v = 0; v < 4; v++) begin
                ext_in[1:0] = 2'(v); #2;
                check("R4", ref_evt(cur_word));
            end
        end

        // R5 R6 R7 R8: random words and random status
        for (int i = 0; i < 400; i++) begin
            put_word(OFS, 17'($urandom));
            rand_status(); #2;
            check("R5_R6_R7_R8", ref_evt(cur_word));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule